// File: doc/BRIEF.md
# FIFO-Threshold DMA Transfer Trigger

This block decides when each of two independent DMA channels, one moving frame data out of memory into a transmit FIFO and one moving received data from a receive FIFO into memory, may ask the bus master for its next transfer. The transmit channel compares the free space in its FIFO with one configured burst and with the bytes still left in the current frame. The receive channel compares the FIFO fill level with one burst, looks for an end-of-frame marker, and limits each transfer to the room left in the destination buffer.

Software or a descriptor engine loads a channel with a buffer address and a byte length, then enables it. When the channel's trigger condition holds, the channel raises a request that carries a start address and a beat count. The request stays up until the bus master returns a one-cycle completion pulse. On completion the channel moves its address forward and reduces its remaining length by the bytes moved. The two channels start and stop on their own enables. With the default parameters a burst is 8 beats of 4 bytes, which is 32 bytes.

Top module: `dma_xfer_trigger`

## Requirements
- R1: After a synchronous reset, both request outputs and both running outputs are low.
- R2: A running transmit channel issues a full burst (32 bytes, beat count 8) when its remaining frame length is at least 32 and the free space reported in its FIFO is at least 32. It issues nothing while the free space is below 32.
- R3: When the transmit remaining length is between 1 and 31, the channel issues a shortened request for exactly that many bytes once the free space is at least that amount. The beat count is the byte count divided by 4, rounded up. With a remaining length of zero it issues nothing.
- R4: A running receive channel with no short end-of-frame pending issues a full burst (32 bytes, beat count 8) when its FIFO holds at least 32 bytes.
- R5: When the end-of-frame flag is high and the bytes up to and including the marker are between 1 and 31, the receive channel requests exactly that many bytes, whatever the FIFO level.
- R6: A receive request never exceeds the remaining buffer length. Its byte count is the smaller of the amount wanted and the remaining length, and a receive buffer with zero remaining bytes produces no request.
- R7: A request appears on the clock edge that follows the edge on which its condition is sampled. The channel holds at most one request at a time, and its address and beat count stay unchanged until completion.
- R8: A completion pulse while a request is up drops the request on that edge, adds the byte count to the channel address and subtracts it from the remaining length. The next request starts at the advanced address.
- R9: A completion pulse while no request is up has no effect on the address or the remaining length.
- R10: A load while a request is up is ignored. A load in the same cycle as a trigger condition takes priority, and no request is issued on that edge.
- R11: The running output rises one edge after the enable is raised. Dropping the enable stops new requests. An outstanding request still completes, and running falls on the completion edge.
- R12: The channels are independent. The enable, completion and FIFO activity of one channel never change the other channel's request, address or running output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit channel enable |
| tx_load | input | 1 | Load transmit buffer address and frame length |
| tx_load_addr | input | ADDR_W | Transmit buffer start address |
| tx_load_len | input | LEN_W | Transmit frame length in bytes |
| tx_free | input | LVL_W | Free bytes in the transmit FIFO |
| tx_done | input | 1 | Transmit transfer completion pulse |
| tx_req | output | 1 | Transmit request outstanding |
| tx_req_addr | output | ADDR_W | Transmit request start address |
| tx_req_beats | output | LEN_W | Transmit request beat count |
| tx_running | output | 1 | Transmit channel is running |
| rx_en | input | 1 | Receive channel enable |
| rx_load | input | 1 | Load receive buffer address and size |
| rx_load_addr | input | ADDR_W | Receive buffer start address |
| rx_load_len | input | LEN_W | Receive buffer size in bytes |
| rx_level | input | LVL_W | Bytes held in the receive FIFO |
| rx_eof_valid | input | 1 | An end-of-frame marker is in the receive FIFO |
| rx_eof_bytes | input | LVL_W | Bytes held up to and including the marker |
| rx_done | input | 1 | Receive transfer completion pulse |
| rx_req | output | 1 | Receive request outstanding |
| rx_req_addr | output | ADDR_W | Receive request start address |
| rx_req_beats | output | LEN_W | Receive request beat count |
| rx_running | output | 1 | Receive channel is running |

## Verification
The bench sweeps every pairing of transmit remaining length and free space from 0 to 40. This covers the burst boundary at 31, 32 and 33 bytes, where an off-by-one comparison would issue early or stall, and the zero-length case, where a missing guard would issue an empty request. The receive sweep crosses FIFO level with end-of-frame byte counts, so a design that lets a full burst win over a short end-of-frame would carry the transfer into the next frame. A separate sweep of buffer size checks that the byte count is clipped. Directed sequences start from an unaligned address and chain three completions to catch wrong address arithmetic. They also send stray completion pulses, loads during a pending request and loads that coincide with a trigger. One sequence drops the enable mid-transfer, and a design that aborts the transfer would lose it, while one that keeps issuing would never report stopped.

// File: rtl/xfer_trig_pkg.sv
`timescale 1ns/1ps
package xfer_trig_pkg;

    typedef enum logic [1:0] {
        CH_STOPPED = 2'd0,
        CH_RUNNING = 2'd1,
        CH_PENDING = 2'd2
    } ch_state_e;

    // Trigger decision: whether to issue and how many bytes
    typedef struct packed {
        logic        go;
        logic [15:0] nbytes;
    } trig_t;

    // Beats needed for a byte count on a bus of 2**lg bytes (rounded up)
    function automatic logic [15:0] bytes_to_beats(input logic [15:0] nbytes,
                                                   input int unsigned lg);
        logic [15:0] mask;
        mask = 16'((32'd1 << lg) - 32'd1);
        return 16'((nbytes + mask) >> lg);
    endfunction

endpackage

// File: rtl/xfer_trig_cond.sv
`timescale 1ns/1ps
module xfer_trig_cond
    import xfer_trig_pkg::*;
#(
    parameter bit IS_TX       = 1'b1,
    parameter int LVL_W       = 8,
    parameter int LEN_W       = 14,
    parameter int BURST_BYTES = 32
) (
    input  logic [LVL_W-1:0] fifo_bytes,
    input  logic [LEN_W-1:0] rem_bytes,
    input  logic             eof_seen,
    input  logic [LVL_W-1:0] eof_bytes,
    output trig_t            trig
);
    logic [15:0] lvl, rem, eb, bst;
    logic [15:0] tx_want, rx_want, rx_amt, pick;

    always_comb begin
        lvl = 16'(fifo_bytes);
        rem = 16'(rem_bytes);
        eb  = 16'(eof_bytes);
        bst = 16'(BURST_BYTES);

        // Transmit: full burst while a burst of frame remains, else the tail
        if (rem >= bst && lvl >= bst)
            tx_want = bst;
        else if (rem != 16'd0 && rem < bst && lvl >= rem)
            tx_want = rem;
        else
            tx_want = 16'd0;

        // Receive: a short frame end wins, so no transfer crosses a frame
        if (eof_seen && eb != 16'd0 && eb < bst)
            rx_want = eb;
        else if (lvl >= bst)
            rx_want = bst;
        else
            rx_want = 16'd0;
        rx_amt = (rx_want < rem) ? rx_want : rem;

        pick        = IS_TX ? tx_want : rx_amt;
        trig.go     = (pick != 16'd0);
        trig.nbytes = pick;
    end
endmodule

// File: rtl/xfer_trig_chan.sv
`timescale 1ns/1ps
module xfer_trig_chan
    import xfer_trig_pkg::*;
#(
    parameter bit IS_TX       = 1'b1,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 14,
    parameter int LVL_W       = 8,
    parameter int BUS_BYTES   = 4,
    parameter int BURST_BEATS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [LVL_W-1:0]  fifo_bytes,
    input  logic              eof_seen,
    input  logic [LVL_W-1:0]  eof_bytes,
    input  logic              done,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_beats,
    output logic              running
);
    localparam int BURST_BYTES = BUS_BYTES * BURST_BEATS;
    localparam int BUS_LG      = $clog2(BUS_BYTES);

    ch_state_e         st;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  rem;
    logic [ADDR_W-1:0] req_addr_q;
    logic [LEN_W-1:0]  req_bytes_q;
    trig_t             trig;

    xfer_trig_cond #(
        .IS_TX(IS_TX), .LVL_W(LVL_W), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)
    ) u_cond (
        .fifo_bytes(fifo_bytes), .rem_bytes(rem), .eof_seen(eof_seen),
        .eof_bytes(eof_bytes), .trig(trig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= CH_STOPPED;
            cur_addr    <= '0;
            rem         <= '0;
            req_addr_q  <= '0;
            req_bytes_q <= '0;
        end else begin
            case (st)
                CH_STOPPED: begin
                    if (load) begin
                        cur_addr <= load_addr;
                        rem      <= load_len;
                    end
                    if (en) st <= CH_RUNNING;
                end
                CH_RUNNING: begin
                    if (load) begin
                        cur_addr <= load_addr;
                        rem      <= load_len;
                    end
                    if (!en) begin
                        st <= CH_STOPPED;
                    end else if (!load && trig.go) begin
                        req_addr_q  <= cur_addr;
                        req_bytes_q <= LEN_W'(trig.nbytes);
                        st          <= CH_PENDING;
                    end
                end
                CH_PENDING: begin
                    if (done) begin
                        cur_addr <= cur_addr + ADDR_W'(req_bytes_q);
                        rem      <= rem - req_bytes_q;
                        st       <= en ? CH_RUNNING : CH_STOPPED;
                    end
                end
                default: st <= CH_STOPPED;
            endcase
        end
    end

    assign req       = (st == CH_PENDING);
    assign running   = (st != CH_STOPPED);
    assign req_addr  = req_addr_q;
    assign req_beats = LEN_W'(bytes_to_beats(16'(req_bytes_q), BUS_LG));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !done) |=> (req && $stable(req_addr) && $stable(req_beats)));

    // R2
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> (req_beats != '0 && req_beats <= LEN_W'(BURST_BEATS)));

    // R6
    within_len_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> (req_bytes_q <= rem));

    // R8
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (req && done) |=> (!req && cur_addr == $past(req_addr) + ADDR_W'($past(req_bytes_q))));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !req) |=> !running);
endmodule

// File: rtl/dma_xfer_trigger.sv
`timescale 1ns/1ps
module dma_xfer_trigger #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 14,
    parameter int LVL_W       = 8,
    parameter int BUS_BYTES   = 4,
    parameter int BURST_BEATS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              tx_load,
    input  logic [ADDR_W-1:0] tx_load_addr,
    input  logic [LEN_W-1:0]  tx_load_len,
    input  logic [LVL_W-1:0]  tx_free,
    input  logic              tx_done,
    output logic              tx_req,
    output logic [ADDR_W-1:0] tx_req_addr,
    output logic [LEN_W-1:0]  tx_req_beats,
    output logic              tx_running,
    input  logic              rx_en,
    input  logic              rx_load,
    input  logic [ADDR_W-1:0] rx_load_addr,
    input  logic [LEN_W-1:0]  rx_load_len,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_eof_valid,
    input  logic [LVL_W-1:0]  rx_eof_bytes,
    input  logic              rx_done,
    output logic              rx_req,
    output logic [ADDR_W-1:0] rx_req_addr,
    output logic [LEN_W-1:0]  rx_req_beats,
    output logic              rx_running
);
    localparam int NCH = 2;   // index 0 transmit, 1 receive

    logic [NCH-1:0]    en_v, load_v, eof_v, done_v, req_v, run_v;
    logic [ADDR_W-1:0] laddr_v [NCH];
    logic [LEN_W-1:0]  llen_v  [NCH];
    logic [LVL_W-1:0]  lvl_v   [NCH];
    logic [LVL_W-1:0]  eofb_v  [NCH];
    logic [ADDR_W-1:0] raddr_v [NCH];
    logic [LEN_W-1:0]  rbeat_v [NCH];

    assign en_v   = {rx_en, tx_en};
    assign load_v = {rx_load, tx_load};
    assign eof_v  = {rx_eof_valid, 1'b0};
    assign done_v = {rx_done, tx_done};
    assign laddr_v[0] = tx_load_addr;
    assign laddr_v[1] = rx_load_addr;
    assign llen_v[0]  = tx_load_len;
    assign llen_v[1]  = rx_load_len;
    assign lvl_v[0]   = tx_free;
    assign lvl_v[1]   = rx_level;
    assign eofb_v[0]  = '0;
    assign eofb_v[1]  = rx_eof_bytes;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        xfer_trig_chan #(
            .IS_TX(g == 0), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LVL_W(LVL_W),
            .BUS_BYTES(BUS_BYTES), .BURST_BEATS(BURST_BEATS)
        ) u_ch (
            .clk(clk), .rst(rst), .en(en_v[g]), .load(load_v[g]),
            .load_addr(laddr_v[g]), .load_len(llen_v[g]), .fifo_bytes(lvl_v[g]),
            .eof_seen(eof_v[g]), .eof_bytes(eofb_v[g]), .done(done_v[g]),
            .req(req_v[g]), .req_addr(raddr_v[g]), .req_beats(rbeat_v[g]),
            .running(run_v[g])
        );
    end

    assign tx_req       = req_v[0];
    assign tx_req_addr  = raddr_v[0];
    assign tx_req_beats = rbeat_v[0];
    assign tx_running   = run_v[0];
    assign rx_req       = req_v[1];
    assign rx_req_addr  = raddr_v[1];
    assign rx_req_beats = rbeat_v[1];
    assign rx_running   = run_v[1];
endmodule

// File: tb/sim_dma_xfer_trigger.sv
`timescale 1ns/1ps
module sim_dma_xfer_trigger;
    localparam int BURST = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 0, tx_load = 0, tx_done = 0;
    logic [31:0] tx_load_addr = 0;
    logic [13:0] tx_load_len = 0;
    logic [7:0]  tx_free = 0;
    logic        tx_req, tx_running;
    logic [31:0] tx_req_addr;
    logic [13:0] tx_req_beats;
    logic        rx_en = 0, rx_load = 0, rx_done = 0, rx_eof_valid = 0;
    logic [31:0] rx_load_addr = 0;
    logic [13:0] rx_load_len = 0;
    logic [7:0]  rx_level = 0, rx_eof_bytes = 0;
    logic        rx_req, rx_running;
    logic [31:0] rx_req_addr;
    logic [13:0] rx_req_beats;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_xfer_trigger u0 (
        .clk(clk), .rst(rst),
        .tx_en(tx_en), .tx_load(tx_load), .tx_load_addr(tx_load_addr),
        .tx_load_len(tx_load_len), .tx_free(tx_free), .tx_done(tx_done),
        .tx_req(tx_req), .tx_req_addr(tx_req_addr), .tx_req_beats(tx_req_beats),
        .tx_running(tx_running),
        .rx_en(rx_en), .rx_load(rx_load), .rx_load_addr(rx_load_addr),
        .rx_load_len(rx_load_len), .rx_level(rx_level), .rx_eof_valid(rx_eof_valid),
        .rx_eof_bytes(rx_eof_bytes), .rx_done(rx_done),
        .rx_req(rx_req), .rx_req_addr(rx_req_addr), .rx_req_beats(rx_req_beats),
        .rx_running(rx_running)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic int beats_of(input int b);
        return (b + 3) / 4;
    endfunction

    task automatic tx_pulse_done();
        tx_done = 1; step(); tx_done = 0;
    endtask

    task automatic rx_pulse_done();
        rx_done = 1; step(); rx_done = 0;
    endtask

    task automatic tx_load_buf(input logic [31:0] a, input int len);
        tx_load = 1; tx_load_addr = a; tx_load_len = 14'(len);
        step();
        tx_load = 0;
    endtask

    task automatic rx_load_buf(input logic [31:0] a, input int len);
        rx_load = 1; rx_load_addr = a; rx_load_len = 14'(len);
        step();
        rx_load = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1..R12 actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        int want, exp_b;

        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 tx_req", tx_req, 0);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 tx_running", tx_running, 0);
        chk("R1 rx_running", rx_running, 0);

        // R11 enable -> running one edge later; R12 rx unaffected
        tx_en = 1;
        step();
        chk("R11 tx_running rise", tx_running, 1);
        chk("R12 rx_running idle", rx_running, 0);

        // R2 / R3 sweep of remaining length x free space
        for (int r = 0; r <= 40; r++) begin
            for (int f = 0; f <= 40; f++) begin
                a = 32'h2000_0000 + 32'(r * 256 + f * 4);
                tx_free = 0;
                tx_load_buf(a, r);
                tx_free = 8'(f);
                step();
                if (r >= BURST && f >= BURST) exp_b = BURST;
                else if (r > 0 && r < BURST && f >= r) exp_b = r;
                else exp_b = 0;
                if (exp_b == BURST) chk("R2 tx full burst req", tx_req, 1);
                else if (exp_b != 0) chk("R3 tx tail req", tx_req, 1);
                else chk("R2 R3 tx no req", tx_req, 0);
                if (exp_b != 0 && tx_req) begin
                    chk("R3 tx addr", tx_req_addr, a);
                    chk("R3 tx beats", tx_req_beats, 64'(beats_of(exp_b)));
                    tx_free = 0;
                    tx_pulse_done();
                    chk("R8 tx req drops", tx_req, 0);
                end
            end
        end

        // R8 chained completions from an unaligned address
        tx_free = 0;
        tx_load_buf(32'h1000_0003, 70);
        tx_free = 8'd255;
        step();
        chk("R8 req1 addr", tx_req_addr, 32'h1000_0003);
        chk("R8 req1 beats", tx_req_beats, 8);
        tx_pulse_done();
        step();
        chk("R8 req2 addr", tx_req_addr, 32'h1000_0023);
        chk("R8 req2 beats", tx_req_beats, 8);
        tx_pulse_done();
        step();
        chk("R8 req3 addr", tx_req_addr, 32'h1000_0043);
        chk("R8 req3 beats", tx_req_beats, 2);
        tx_pulse_done();
        step();
        chk("R8 frame exhausted", tx_req, 0);

        // R9 stray completion has no effect
        tx_free = 0;
        tx_load_buf(32'h0000_4000, 100);
        tx_pulse_done();
        tx_free = 8'd255;
        step();
        chk("R9 addr unchanged", tx_req_addr, 32'h0000_4000);
        chk("R9 beats full", tx_req_beats, 8);
        tx_pulse_done();
        step();
        chk("R9 next addr", tx_req_addr, 32'h0000_4020);

        // R10 load while pending ignored
        tx_load_buf(32'h0000_9000, 5);
        chk("R10 req held", tx_req, 1);
        chk("R10 addr held", tx_req_addr, 32'h0000_4020);
        tx_pulse_done();
        step();
        chk("R10 old buffer continues", tx_req_addr, 32'h0000_4040);
        chk("R10 old length 36 left", tx_req_beats, 8);
        tx_free = 0;
        tx_pulse_done();
        // R10 load beats a simultaneous trigger
        tx_free = 8'd255;
        tx_load_buf(32'h0000_7000, 64);
        chk("R10 no req on load edge", tx_req, 0);
        step();
        chk("R10 req after load", tx_req_addr, 32'h0000_7000);

        // R12 rx runs while tx request is held
        rx_en = 1;
        rx_level = 8'd40;
        rx_load_buf(32'h0008_0000, 500);
        step();
        chk("R12 rx req", rx_req, 1);
        chk("R12 rx addr", rx_req_addr, 32'h0008_0000);
        rx_level = 0;
        rx_pulse_done();
        chk("R12 tx req held", tx_req, 1);
        chk("R12 tx addr held", tx_req_addr, 32'h0000_7000);
        chk("R12 tx running", tx_running, 1);

        // R11 drain: drop enable with request outstanding
        tx_en = 0;
        step();
        chk("R11 req kept", tx_req, 1);
        chk("R11 still running", tx_running, 1);
        tx_pulse_done();
        chk("R11 req done", tx_req, 0);
        chk("R11 stopped", tx_running, 0);
        step(); step();
        chk("R11 no new req", tx_req, 0);
        chk("R12 rx still running", rx_running, 1);

        // R4 / R5 receive sweep
        for (int lv = 0; lv <= 40; lv++) begin
            for (int ev = 0; ev <= 1; ev++) begin
                for (int eb = 0; eb <= (ev ? 40 : 0); eb++) begin
                    rx_level = 0; rx_eof_valid = 0; rx_eof_bytes = 0;
                    a = 32'h3000_0000 + 32'(lv * 1024 + eb * 8);
                    rx_load_buf(a, 1000);
                    rx_level = 8'(lv); rx_eof_valid = 1'(ev); rx_eof_bytes = 8'(eb);
                    step();
                    if (ev == 1 && eb > 0 && eb < BURST) want = eb;
                    else if (lv >= BURST) want = BURST;
                    else want = 0;
                    if (want == BURST) chk("R4 rx full burst req", rx_req, 1);
                    else if (want != 0) chk("R5 rx eof req", rx_req, 1);
                    else chk("R4 R5 rx no req", rx_req, 0);
                    if (want != 0 && rx_req) begin
                        chk("R5 rx addr", rx_req_addr, a);
                        chk("R5 rx beats", rx_req_beats, 64'(beats_of(want)));
                        rx_level = 0; rx_eof_valid = 0;
                        rx_pulse_done();
                    end
                end
            end
        end

        // R6 buffer cap sweep
        for (int len = 0; len <= 40; len++) begin
            for (int ev = 0; ev <= 1; ev++) begin
                rx_level = 0; rx_eof_valid = 0;
                rx_load_buf(32'h4000_0000, len);
                rx_level = 8'd40; rx_eof_valid = 1'(ev); rx_eof_bytes = 8'd5;
                step();
                want = ev ? 5 : BURST;
                exp_b = (want < len) ? want : len;
                chk("R6 rx req present", rx_req, (exp_b != 0));
                if (exp_b != 0 && rx_req) begin
                    chk("R6 rx capped beats", rx_req_beats, 64'(beats_of(exp_b)));
                    rx_level = 0; rx_eof_valid = 0;
                    rx_pulse_done();
                end
            end
        end

        // R7 request timing and hold across idle cycles
        rx_level = 0; rx_eof_valid = 0;
        rx_load_buf(32'h5000_0000, 200);
        rx_level = 8'd33;
        chk("R7 no req before edge", rx_req, 0);
        step();
        chk("R7 req next edge", rx_req, 1);
        rx_level = 0;
        step(); step();
        chk("R7 req held", rx_req, 1);
        chk("R7 addr held", rx_req_addr, 32'h5000_0000);
        rx_level = 8'd64;
        rx_pulse_done();
        chk("R7 single outstanding", rx_req, 0);
        step();
        chk("R7 next req addr", rx_req_addr, 32'h5000_0020);

        finished = 1;
        summary();
        $finish;
    end
endmodule